// File: doc/BRIEF.md
# Interleaved Cell Reassembly Controller

This block sits behind the header stage of a cell receiver and handles one decoded cell header per clock. For each header it decides whether the cell is kept or dropped, and it tracks the state of many packets whose cells arrive interleaved. One decision engine serves every packet in flight. A table indexed by message identifier holds a small reassembly tag for each packet in flight. A pool of free tags supplies new tags. A per-tag context holds the packet's list head, its next cell position and an idle-age count.

Buffer memory is left to an external allocator. At a packet start the controller takes a buffer unit that the allocator offers, and it uses that unit as the packet's list head. For each accepted cell it issues a store request (list head, cell position). When a packet is dropped part-way, it issues a release request for the head. Completed packets leave through a small report queue as (list head, length in cells) pairs, in the order in which they complete.

Top module: `cell_reasm_ctrl`

## Requirements
- R1: During and right after a synchronous active-low reset, no cell is accepted, no store or release request is issued and the report queue is empty. All NTAG tags are free.
- R2: Kind codes on `cell_kind` are 0 for a packet start, 1 for a middle cell, 2 for a packet end and 3 for a one-cell packet. A start cell is accepted only when `cell_hit` is high, `unit_avail` is high, and the identifier already owns a tag or a free tag exists. On acceptance `unit_take` pulses in the same cycle and a store request with head `unit_head` and position 0 follows one cycle later.
- R3: A middle or end cell whose identifier has no reassembly in progress is discarded. It gives no acceptance, no store request and no report.
- R4: A middle cell of a live reassembly is accepted with a store request carrying that packet's list head and a position one above that of its previous cell.
- R5: An end cell of a live reassembly is accepted and queues a report of its list head and total cell count. Its identifier then has no reassembly in progress.
- R6: Reports leave in end-cell arrival order, not in start order.
- R7: Up to NTAG reassemblies run at once. A further start cell for a new identifier is refused until one of them ends, and it is then accepted.
- R8: A reassembly that sees TMO_LIM timeout ticks with no accepted cell is dropped. A release request for its head follows, and later cells for it are discarded. Each accepted cell restarts its count.
- R9: A start cell for an identifier that already has a reassembly drops the old one: a release request carries the old head, and the new packet begins at position 0 with a new head.
- R10: A one-cell packet is accepted when `cell_hit`, `unit_avail` and report space allow it. It queues a report of length 1 at once and uses no tag, so it is accepted even when all tags are busy.
- R11: While the report queue is full, one-cell packets are refused. An end cell then drops its packet: it is not accepted, a release request carries its head, and its identifier is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_vld | input | 1 | A cell header is present this cycle |
| cell_kind | input | 2 | Cell kind code (see R2) |
| cell_mid | input | MID_W | Message identifier |
| cell_hit | input | 1 | Destination address matches this node |
| tmo_tick | input | 1 | Timeout tick |
| unit_avail | input | 1 | Allocator offers a free buffer unit |
| unit_head | input | UNIT_W | Offered buffer unit |
| unit_take | output | 1 | Offered unit is taken this cycle |
| cell_acc | output | 1 | Previous cycle's cell was accepted |
| st_vld | output | 1 | Store request valid |
| st_head | output | UNIT_W | List head for the store |
| st_pos | output | POS_W | Cell position within the packet |
| rel_vld | output | 1 | Release request valid |
| rel_head | output | UNIT_W | List head to release |
| rpt_vld | output | 1 | Report queue not empty |
| rpt_head | output | UNIT_W | Report list head |
| rpt_len | output | POS_W | Report length in cells |
| rpt_pop | input | 1 | Consume the front report |

## Verification
Some properties are checked on every cycle by the assertions. Neither the tag pool nor the report queue is ever pushed when full or popped when empty. Only a live context is advanced or freed. An offered unit is taken only while it is offered. Acceptance follows a presented cell, and every report has a non-zero length. Other behaviours need the scenarios: completion-order reporting across interleaved packets, exhaustion and reuse of tags, the exact tick count to a timeout with its refresh, abandonment on a repeated start, and end cells that meet a full report queue.

// File: rtl/creasm_pkg.sv
package creasm_pkg;
    // Encoded kind of an incoming cell header.
    typedef enum logic [1:0] {
        CK_BOM = 2'd0,
        CK_COM = 2'd1,
        CK_EOM = 2'd2,
        CK_SSM = 2'd3
    } cell_kind_e;
endpackage

// File: rtl/creasm_fifo.sv
// Circular queue with an occupancy count.
// Assumes the user never pushes when full or pops when empty.
// When PRELOAD is set, reset fills it with the values 1..DEPTH.
module creasm_fifo #(
    parameter int W       = 8,
    parameter int DEPTH   = 4,
    parameter bit PRELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage, pointers and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= PRELOAD ? W'(i + 1) : '0;
            rp  <= '0;
            wp  <= '0;
            cnt <= PRELOAD ? CW'(DEPTH) : '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= step(wp);
            end
            if (pop) rp <= step(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop)); // R7
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);          // R11
endmodule

// File: rtl/creasm_mid_table.sv
// Lookup table from message identifier to reassembly tag.
// Tag 0 means no reassembly is in progress. Reset clears every entry.
// Reads are combinational. There is one write port.
module creasm_mid_table #(
    parameter int MID_W = 10,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MID_W-1:0] rd_mid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [MID_W-1:0] wr_mid,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int ENTRIES = 1 << MID_W;

    logic [TAG_W-1:0] tbl [ENTRIES];

    // Clear on reset, otherwise take the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_mid] <= wr_tag;
        end
    end

    assign rd_tag = tbl[rd_mid];
endmodule

// File: rtl/creasm_ctx_bank.sv
// Per-tag reassembly context: live flag, list head, next position,
// owning identifier and idle age. Tags 1..NTAG are valid; entry 0 is unused.
// Assumes init, advance and kill never name the same tag in one cycle.
// When more than one context has expired, the lowest-numbered one is reported first.
module creasm_ctx_bank #(
    parameter int NTAG    = 16,
    parameter int TAG_W   = 5,
    parameter int UNIT_W  = 12,
    parameter int POS_W   = 8,
    parameter int MID_W   = 10,
    parameter int TMO_LIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [UNIT_W-1:0] rd_head,
    output logic [POS_W-1:0]  rd_pos,
    output logic              rd_live,
    input  logic              init_en,
    input  logic [TAG_W-1:0]  init_tag,
    input  logic [UNIT_W-1:0] init_head,
    input  logic [MID_W-1:0]  init_mid,
    input  logic              adv_en,
    input  logic [TAG_W-1:0]  adv_tag,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  kill_tag,
    input  logic              tick,
    output logic              exp_any,
    output logic [TAG_W-1:0]  exp_tag,
    output logic [UNIT_W-1:0] exp_head,
    output logic [MID_W-1:0]  exp_mid
);
    localparam int AGE_W = $clog2(TMO_LIM + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(TMO_LIM);

    logic              act  [NTAG+1];
    logic [UNIT_W-1:0] head [NTAG+1];
    logic [POS_W-1:0]  pos  [NTAG+1];
    logic [MID_W-1:0]  mid  [NTAG+1];
    logic [AGE_W-1:0]  age  [NTAG+1];
    logic [NTAG:0]     exp_vec;

    // Context fields: start, advance and free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t <= NTAG; t++) begin
                act[t]  <= 1'b0;
                head[t] <= '0;
                pos[t]  <= '0;
                mid[t]  <= '0;
            end
        end else begin
            if (init_en) begin
                act[init_tag]  <= 1'b1;
                head[init_tag] <= init_head;
                pos[init_tag]  <= POS_W'(1);
                mid[init_tag]  <= init_mid;
            end
            if (adv_en)  pos[adv_tag] <= pos[adv_tag] + 1'b1;
            if (kill_en) act[kill_tag] <= 1'b0;
        end
    end

    // Idle ages: cleared by activity, advanced by ticks, held at the limit.
    always_ff @(posedge clk) begin
        for (int t = 0; t <= NTAG; t++) begin
            if (!rst_n)
                age[t] <= '0;
            else if ((init_en && init_tag == TAG_W'(t)) || (adv_en && adv_tag == TAG_W'(t)))
                age[t] <= '0;
            else if (tick && act[t] && age[t] != AGE_MAX)
                age[t] <= age[t] + 1'b1;
        end
    end

    assign exp_vec[0] = 1'b0;
    for (genvar g = 1; g <= NTAG; g++) begin : g_exp
        assign exp_vec[g] = act[g] && (age[g] == AGE_MAX);
    end

    // Pick the lowest expired tag.
    always_comb begin
        exp_tag = '0;
        for (int t = NTAG; t >= 1; t--) if (exp_vec[t]) exp_tag = TAG_W'(t);
    end

    assign exp_any  = |exp_vec;
    assign exp_head = head[exp_tag];
    assign exp_mid  = mid[exp_tag];
    assign rd_head  = head[rd_tag];
    assign rd_pos   = pos[rd_tag];
    assign rd_live  = act[rd_tag] && (age[rd_tag] != AGE_MAX);

    AST_KILL_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) kill_en |-> act[kill_tag]); // R5
    AST_ADV_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |-> (act[adv_tag] && age[adv_tag] != AGE_MAX)); // R8
endmodule

// File: rtl/cell_reasm_ctrl.sv
// Interleaved cell reassembly controller. Each cycle it decides on one cell
// header using the identifier table, the free-tag pool and the context bank.
// It issues store and release requests and queues completion reports.
// Assumes the allocator keeps unit_head stable while unit_avail is high.
// Expired contexts are freed only in cycles with no cell.
module cell_reasm_ctrl
    import creasm_pkg::*;
#(
    parameter int MID_W     = 10,
    parameter int NTAG      = 16,
    parameter int UNIT_W    = 12,
    parameter int POS_W     = 8,
    parameter int TMO_LIM   = 3,
    parameter int RPT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_vld,
    input  logic [1:0]        cell_kind,
    input  logic [MID_W-1:0]  cell_mid,
    input  logic              cell_hit,
    input  logic              tmo_tick,
    input  logic              unit_avail,
    input  logic [UNIT_W-1:0] unit_head,
    output logic              unit_take,
    output logic              cell_acc,
    output logic              st_vld,
    output logic [UNIT_W-1:0] st_head,
    output logic [POS_W-1:0]  st_pos,
    output logic              rel_vld,
    output logic [UNIT_W-1:0] rel_head,
    output logic              rpt_vld,
    output logic [UNIT_W-1:0] rpt_head,
    output logic [POS_W-1:0]  rpt_len,
    input  logic              rpt_pop
);
    localparam int TAG_W = $clog2(NTAG + 1);
    localparam int RW    = UNIT_W + POS_W;

    cell_kind_e        kind;
    logic [TAG_W-1:0]  lut_tag, tbl_tag, tagq_din, tagq_dout, new_tag;
    logic [MID_W-1:0]  tbl_mid, exp_mid;
    logic              tbl_we, has_tag, tagq_push, tagq_pop, tagq_full, tagq_empty;
    logic [UNIT_W-1:0] rd_head, exp_head;
    logic [POS_W-1:0]  rd_pos;
    logic              rd_live, exp_any;
    logic [TAG_W-1:0]  exp_tag, kill_tag;
    logic              init_en, adv_en, kill_en;
    logic              rpt_push, rpt_full, rpt_empty;
    logic [RW-1:0]     rpt_din, rpt_dout;
    logic              acc_d, st_d, rel_d;
    logic [UNIT_W-1:0] sth_d, relh_d;
    logic [POS_W-1:0]  stp_d;

    assign kind    = cell_kind_e'(cell_kind);
    assign has_tag = (lut_tag != '0);
    assign new_tag = has_tag ? lut_tag : tagq_dout;

    creasm_mid_table #(.MID_W(MID_W), .TAG_W(TAG_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .rd_mid(cell_mid), .rd_tag(lut_tag),
        .wr_en(tbl_we), .wr_mid(tbl_mid), .wr_tag(tbl_tag));

    creasm_fifo #(.W(TAG_W), .DEPTH(NTAG), .PRELOAD(1'b1)) u_tagq (
        .clk(clk), .rst_n(rst_n), .push(tagq_push), .din(tagq_din), .pop(tagq_pop),
        .dout(tagq_dout), .full(tagq_full), .empty(tagq_empty));

    creasm_ctx_bank #(.NTAG(NTAG), .TAG_W(TAG_W), .UNIT_W(UNIT_W), .POS_W(POS_W),
                      .MID_W(MID_W), .TMO_LIM(TMO_LIM)) u_ctx (
        .clk(clk), .rst_n(rst_n), .rd_tag(lut_tag), .rd_head(rd_head), .rd_pos(rd_pos),
        .rd_live(rd_live), .init_en(init_en), .init_tag(new_tag), .init_head(unit_head),
        .init_mid(cell_mid), .adv_en(adv_en), .adv_tag(lut_tag), .kill_en(kill_en),
        .kill_tag(kill_tag), .tick(tmo_tick), .exp_any(exp_any), .exp_tag(exp_tag),
        .exp_head(exp_head), .exp_mid(exp_mid));

    creasm_fifo #(.W(RW), .DEPTH(RPT_DEPTH), .PRELOAD(1'b0)) u_rptq (
        .clk(clk), .rst_n(rst_n), .push(rpt_push), .din(rpt_din), .pop(rpt_pop && !rpt_empty),
        .dout(rpt_dout), .full(rpt_full), .empty(rpt_empty));

    // Accept or discard decision, and reaping of expired contexts in idle cycles.
    always_comb begin
        acc_d = 1'b0; st_d = 1'b0; sth_d = '0; stp_d = '0; rel_d = 1'b0; relh_d = '0;
        unit_take = 1'b0; tagq_pop = 1'b0; tagq_push = 1'b0; tagq_din = lut_tag;
        tbl_we = 1'b0; tbl_mid = cell_mid; tbl_tag = '0;
        init_en = 1'b0; adv_en = 1'b0; kill_en = 1'b0; kill_tag = lut_tag;
        rpt_push = 1'b0; rpt_din = '0;
        if (cell_vld) begin
            case (kind)
                CK_BOM: if (cell_hit && unit_avail && (has_tag || !tagq_empty)) begin
                    acc_d = 1'b1; unit_take = 1'b1; st_d = 1'b1; sth_d = unit_head;
                    tagq_pop = !has_tag; tbl_we = 1'b1; tbl_tag = new_tag; init_en = 1'b1;
                    rel_d = has_tag; relh_d = rd_head;
                end
                CK_COM: if (has_tag && rd_live) begin
                    acc_d = 1'b1; st_d = 1'b1; sth_d = rd_head; stp_d = rd_pos; adv_en = 1'b1;
                end
                CK_EOM: if (has_tag && rd_live) begin
                    tbl_we = 1'b1; kill_en = 1'b1; tagq_push = 1'b1;
                    if (!rpt_full) begin
                        acc_d = 1'b1; st_d = 1'b1; sth_d = rd_head; stp_d = rd_pos;
                        rpt_push = 1'b1; rpt_din = {rd_head, rd_pos + POS_W'(1)};
                    end else begin
                        rel_d = 1'b1; relh_d = rd_head;
                    end
                end
                default: if (cell_hit && unit_avail && !rpt_full) begin
                    acc_d = 1'b1; unit_take = 1'b1; st_d = 1'b1; sth_d = unit_head;
                    rpt_push = 1'b1; rpt_din = {unit_head, POS_W'(1)};
                end
            endcase
        end else if (exp_any) begin
            rel_d = 1'b1; relh_d = exp_head; tbl_we = 1'b1; tbl_mid = exp_mid;
            kill_en = 1'b1; kill_tag = exp_tag; tagq_push = 1'b1; tagq_din = exp_tag;
        end
    end

    // Register the per-cell outcome onto the request ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_acc <= 1'b0; st_vld <= 1'b0; st_head <= '0; st_pos <= '0;
            rel_vld <= 1'b0; rel_head <= '0;
        end else begin
            cell_acc <= acc_d; st_vld <= st_d; st_head <= sth_d; st_pos <= stp_d;
            rel_vld <= rel_d; rel_head <= relh_d;
        end
    end

    assign rpt_vld  = !rpt_empty;
    assign rpt_head = rpt_dout[RW-1:POS_W];
    assign rpt_len  = rpt_dout[POS_W-1:0];

    AST_TAKE_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n) unit_take |-> unit_avail); // R2
    AST_ACC_AFTER_CELL: assert property (@(posedge clk) disable iff (!rst_n) cell_acc |-> $past(cell_vld)); // R3
    AST_SSM_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_vld && cell_kind == 2'd3) |-> !tagq_pop); // R10
    AST_RPT_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) rpt_vld |-> (rpt_len != '0)); // R5
    AST_TAGS_NEVER_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n) tagq_push |-> !tagq_full); // R7
endmodule

// File: tb/cell_reasm_ctrl_tb.sv
module cell_reasm_ctrl_tb_top;
    localparam int MID_W = 10, NTAG = 16, UNIT_W = 12, POS_W = 8, TMO_LIM = 3, RPT_DEPTH = 4;
    localparam logic [1:0] K_BOM = 2'd0, K_COM = 2'd1, K_EOM = 2'd2, K_SSM = 2'd3;

    logic clk = 1'b0;
    logic rst_n, cell_vld, cell_hit, tmo_tick, unit_avail, unit_take, cell_acc;
    logic [1:0] cell_kind;
    logic [MID_W-1:0] cell_mid;
    logic [UNIT_W-1:0] unit_head, st_head, rel_head, rpt_head;
    logic [POS_W-1:0] st_pos, rpt_len;
    logic st_vld, rel_vld, rpt_vld, rpt_pop;

    int total = 0, bad = 0;
    bit done = 0;
    logic [UNIT_W+POS_W-1:0] exp_q [$];
    logic [UNIT_W-1:0] nxt_head = 12'h100;
    logic o_take, o_acc, o_st, o_rel;
    logic [UNIT_W-1:0] o_sh, o_relh;
    logic [POS_W-1:0] o_sp;
    logic [UNIT_W-1:0] hs [17];
    logic [UNIT_W-1:0] ha, hb;

    always #5 clk = ~clk;

    cell_reasm_ctrl #(.MID_W(MID_W), .NTAG(NTAG), .UNIT_W(UNIT_W), .POS_W(POS_W),
                      .TMO_LIM(TMO_LIM), .RPT_DEPTH(RPT_DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_kind(cell_kind), .cell_mid(cell_mid),
        .cell_hit(cell_hit), .tmo_tick(tmo_tick), .unit_avail(unit_avail), .unit_head(unit_head),
        .unit_take(unit_take), .cell_acc(cell_acc), .st_vld(st_vld), .st_head(st_head),
        .st_pos(st_pos), .rel_vld(rel_vld), .rel_head(rel_head), .rpt_vld(rpt_vld),
        .rpt_head(rpt_head), .rpt_len(rpt_len), .rpt_pop(rpt_pop));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present one cell at a falling edge and capture the result one edge later.
    task automatic send(input logic [1:0] k, input int mid, input bit hit);
        cell_vld = 1'b1; cell_kind = k; cell_mid = MID_W'(mid); cell_hit = hit;
        #2 o_take = unit_take;
        @(negedge clk);
        o_acc = cell_acc; o_st = st_vld; o_sh = st_head; o_sp = st_pos;
        o_rel = rel_vld; o_relh = rel_head;
        cell_vld = 1'b0; cell_hit = 1'b0;
        if (o_take) begin
            nxt_head = nxt_head + 1'b1;
            unit_head = nxt_head;
        end
    endtask

    task automatic idle(input bit tick);
        tmo_tick = tick;
        @(negedge clk);
        tmo_tick = 1'b0;
        o_rel = rel_vld; o_relh = rel_head; o_acc = cell_acc;
    endtask

    task automatic expect_rpt(input logic [UNIT_W-1:0] h, input int len);
        exp_q.push_back({h, POS_W'(len)});
    endtask

    // Monitor: compare each report leaving the queue against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1 && rpt_vld && rpt_pop && !done) begin
                if (exp_q.size() == 0) chk("R6 unexpected report", {rpt_head, rpt_len}, 0);
                else chk("R6 report order/content", {rpt_head, rpt_len}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cell_vld = 1'b0; cell_kind = '0; cell_mid = '0; cell_hit = 1'b0;
        tmo_tick = 1'b0; unit_avail = 1'b1; unit_head = nxt_head; rpt_pop = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 acc in reset", cell_acc, 0);
        chk("R1 store in reset", st_vld, 0);
        chk("R1 release in reset", rel_vld, 0);
        chk("R1 report empty", rpt_vld, 0);
        rst_n = 1'b1;

        // Interleaved packets, completion-ordered reports (R2 R4 R5 R6)
        ha = nxt_head; send(K_BOM, 5, 1);
        chk("R2 bom take", o_take, 1); chk("R2 bom acc", o_acc, 1);
        chk("R2 bom head", o_sh, ha); chk("R2 bom pos", o_sp, 0);
        hb = nxt_head; send(K_BOM, 9, 1); chk("R2 second bom head", o_sh, hb);
        send(K_COM, 5, 0); chk("R4 com head", o_sh, ha); chk("R4 com pos", o_sp, 1);
        send(K_COM, 9, 0); chk("R4 com pos b", o_sp, 1);
        send(K_COM, 9, 0); chk("R4 com pos b2", o_sp, 2);
        expect_rpt(hb, 4); send(K_EOM, 9, 0); chk("R5 eom acc", o_acc, 1); chk("R5 eom pos", o_sp, 3);
        expect_rpt(ha, 3); send(K_EOM, 5, 0); chk("R6 second eom acc", o_acc, 1);
        send(K_COM, 9, 0); chk("R5 after end discarded", o_acc, 0); chk("R5 no store", o_st, 0);

        // Unknown identifiers (R3)
        send(K_COM, 7, 1); chk("R3 com unknown acc", o_acc, 0); chk("R3 com unknown store", o_st, 0);
        send(K_EOM, 7, 1); chk("R3 eom unknown acc", o_acc, 0);

        // Start refused without address match or without a unit (R2)
        send(K_BOM, 8, 0); chk("R2 no hit acc", o_acc, 0); chk("R2 no hit take", o_take, 0);
        send(K_COM, 8, 0); chk("R3 com after refused bom", o_acc, 0);
        unit_avail = 1'b0;
        send(K_BOM, 8, 1); chk("R2 no unit acc", o_acc, 0); chk("R2 no unit take", o_take, 0);
        unit_avail = 1'b1;

        // One-cell packet (R10)
        expect_rpt(nxt_head, 1); send(K_SSM, 12, 1);
        chk("R10 ssm acc", o_acc, 1); chk("R10 ssm take", o_take, 1); chk("R10 ssm pos", o_sp, 0);
        send(K_SSM, 12, 0); chk("R10 ssm no hit", o_acc, 0);

        // Repeated start abandons (R9)
        ha = nxt_head; send(K_BOM, 20, 1);
        send(K_COM, 20, 0);
        hb = nxt_head; send(K_BOM, 20, 1);
        chk("R9 restart acc", o_acc, 1); chk("R9 release", o_rel, 1); chk("R9 release head", o_relh, ha);
        chk("R9 new head", o_sh, hb); chk("R9 new pos", o_sp, 0);
        expect_rpt(hb, 2); send(K_EOM, 20, 0); chk("R9 end pos", o_sp, 1);

        // Tag exhaustion (R7) and tag-free one-cell packet (R10)
        for (int i = 0; i < NTAG; i++) begin
            hs[i] = nxt_head; send(K_BOM, 100 + i, 1);
            chk("R7 fill acc", o_acc, 1);
        end
        send(K_BOM, 116, 1); chk("R7 exhausted acc", o_acc, 0); chk("R7 exhausted take", o_take, 0);
        expect_rpt(nxt_head, 1); send(K_SSM, 200, 1); chk("R10 ssm with no tags", o_acc, 1);
        expect_rpt(hs[0], 2); send(K_EOM, 100, 0);
        hs[16] = nxt_head; send(K_BOM, 116, 1); chk("R7 reuse acc", o_acc, 1);
        for (int i = 1; i <= NTAG; i++) begin
            expect_rpt(hs[i], 2); send(K_EOM, 100 + i, 0);
            chk("R7 drain acc", o_acc, 1);
        end

        // Timeout (R8)
        ha = nxt_head; send(K_BOM, 30, 1);
        idle(1); chk("R8 tick1 no release", o_rel, 0);
        idle(1); chk("R8 tick2 no release", o_rel, 0);
        idle(1); chk("R8 tick3 no release yet", o_rel, 0);
        idle(0); chk("R8 release", o_rel, 1); chk("R8 release head", o_relh, ha);
        send(K_COM, 30, 0); chk("R8 late cell discarded", o_acc, 0);
        ha = nxt_head; send(K_BOM, 31, 1);
        idle(1); idle(1);
        send(K_COM, 31, 0); chk("R8 refresh acc", o_acc, 1);
        idle(1); idle(1); idle(0); chk("R8 refreshed no release", o_rel, 0);
        expect_rpt(ha, 3); send(K_EOM, 31, 0); chk("R8 refreshed end", o_acc, 1);

        // Full report queue (R11)
        repeat (4) idle(0);
        rpt_pop = 1'b0;
        for (int i = 0; i < RPT_DEPTH; i++) begin
            expect_rpt(nxt_head, 1); send(K_SSM, 300 + i, 1);
        end
        send(K_SSM, 310, 1); chk("R11 ssm refused", o_acc, 0); chk("R11 ssm no take", o_take, 0);
        ha = nxt_head; send(K_BOM, 40, 1); chk("R11 bom acc", o_acc, 1);
        send(K_EOM, 40, 0); chk("R11 eom refused", o_acc, 0);
        chk("R11 eom release", o_rel, 1); chk("R11 eom release head", o_relh, ha);
        send(K_COM, 40, 0); chk("R11 identifier freed", o_acc, 0);
        rpt_pop = 1'b1;
        repeat (10) idle(0);
        chk("R6 all reports seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule